// File: doc/BRIEF.md
# Embedded Operation Busy Status Generator

This block sits on the flash side of a byte-wide nonvolatile array and runs the internal part of a write operation. A one-cycle start pulse carries the kind of operation (byte program or whole-array erase), a target address and a data byte. The block then counts an operation time set by a parameter, and after that it updates the array through its write port. A program merges the new byte into the stored byte with a bitwise AND, so it can only clear bits. An erase sweeps every address and writes all ones, but it skips the low boot sector when the lock input is high.

While an operation is in flight there is no separate ready pin. The state of the operation is carried in the data returned by normal reads. The top data bit is a polarity flag: during a program it is the inverse of the top bit of the loaded byte. Bit 6 changes on each read. Software polls with ordinary reads until the true data comes back. Once the block is idle, reads return array contents and a new start is accepted. A start that arrives while busy is dropped and raises a sticky error flag.

The array itself and the command decoding are outside the block. The array is expected to have a synchronous read port, with data valid one cycle after the address, and a write port that it samples on the clock edge.

Top module: `busy_status_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `err`, `dout_vld` and `wr_en` are 0 and `dout` is all zeros.
- R2: A start accepted while idle raises `busy` from the next cycle. `busy` stays high for PROG_CYCLES+2 cycles for a program (`start_erase`=0) and for ERASE_CYCLES+2^ADDR_W cycles for an erase (`start_erase`=1).
- R3: A read taken while a program is busy returns, in bit 7, the inverse of bit 7 of the loaded byte, and in bits 5..0 the loaded byte's bits 5..0.
- R4: A read taken while an erase is busy returns 0 in bit 7 and ones in bits 5..0.
- R5: Bit 6 of busy reads is cleared at each accepted start. The first busy read returns 1, and each later busy read of the same operation returns the inverse of the previous one.
- R6: A read strobe on `rd_en` gives a one-cycle `dout_vld` pulse two clock edges later, with the result on `dout`.
- R7: A read taken while idle returns the array byte at `rd_addr`.
- R8: At the end of a program, the byte at the target address becomes its old value AND the loaded byte, and no other address changes.
- R9: At the end of an erase, every address holds all ones, except that addresses below BOOT_WORDS keep their contents when `boot_lock` is 1.
- R10: A start that arrives while busy leaves the running operation unchanged, and it sets `err`, which then stays set until reset.
- R11: A start in the first idle cycle after an operation is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation start |
| start_erase | input | 1 | 1 = erase, 0 = byte program |
| start_addr | input | ADDR_W | Program target address |
| start_data | input | DATA_W | Program data byte |
| boot_lock | input | 1 | Protect addresses below BOOT_WORDS from erase |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| dout | output | DATA_W | Read result (array data or status) |
| dout_vld | output | 1 | Read result valid |
| busy | output | 1 | Operation in flight |
| err | output | 1 | Sticky start-while-busy flag |
| arr_rd_en | output | 1 | Array read enable |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | DATA_W | Array read data, one cycle after address |
| wr_en | output | 1 | Array write enable |
| wr_addr | output | ADDR_W | Array write address |
| wr_data | output | DATA_W | Array write data |

## Verification
Read results are due two edges after the strobe: one edge for the array and one for the output register. The status-or-data choice is made on the state at the strobe edge. `busy` follows a start by one edge. The array changes on the last busy edge, and for a program that edge comes two cycles after the timer expires. The reference model in the bench advances once per rising edge, keeps read results in a two-stage pipeline and keeps a remaining-cycle count for the operation. Every output is compared at the falling edge after the edge on which it is due, and the array is compared against a model copy once each operation has finished.

// File: rtl/busy_status_pkg.sv
package busy_status_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_FETCH,
    ST_WRITE,
    ST_SWEEP
  } seq_state_t;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } op_kind_t;
endpackage

// File: rtl/op_sequencer.sv
module op_sequencer
  import busy_status_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 30,
  parameter int ERASE_CYCLES = 100,
  parameter int BOOT_WORDS   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_kind_t          start_kind,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              boot_lock,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic              busy,
  output logic              err,
  output logic              launch,
  output op_kind_t          op_kind,
  output logic [DATA_W-1:0] op_data,
  output logic              fetch,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

  seq_state_t        state;
  logic [CNT_W-1:0]  timer;
  logic [ADDR_W-1:0] op_addr;
  logic [ADDR_W-1:0] sweep_addr;
  logic              in_boot;

  assign busy       = (state != ST_IDLE);
  assign launch     = start && (state == ST_IDLE);
  assign fetch      = (state == ST_FETCH);
  assign fetch_addr = op_addr;
  assign in_boot    = (int'(sweep_addr) < BOOT_WORDS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      timer      <= '0;
      op_addr    <= '0;
      op_data    <= '0;
      op_kind    <= OP_PROG;
      sweep_addr <= '0;
      err        <= 1'b0;
    end else begin
      if (start && busy) err <= 1'b1;
      case (state)
        ST_IDLE: if (start) begin
          op_kind <= start_kind;
          op_addr <= start_addr;
          op_data <= start_data;
          timer   <= (start_kind == OP_ERASE) ? CNT_W'(ERASE_CYCLES - 1)
                                              : CNT_W'(PROG_CYCLES - 1);
          state   <= ST_COUNT;
        end
        ST_COUNT: begin
          if (timer == '0) begin
            sweep_addr <= '0;
            state      <= (op_kind == OP_ERASE) ? ST_SWEEP : ST_FETCH;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        ST_FETCH: state <= ST_WRITE;
        ST_WRITE: state <= ST_IDLE;
        ST_SWEEP: begin
          sweep_addr <= sweep_addr + 1'b1;
          if (sweep_addr == LAST_ADDR) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    wr_addr = op_addr;
    wr_data = arr_rd_data & op_data;
    if (state == ST_WRITE) begin
      wr_en = 1'b1;
    end else if (state == ST_SWEEP) begin
      wr_en   = !(boot_lock && in_boot);
      wr_addr = sweep_addr;
      wr_data = '1;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R10
  AST_IGNORED_START: assert property (@(posedge clk) disable iff (rst)
    (start && busy) |=> $stable(op_data) && $stable(op_kind)); // R10
endmodule

// File: rtl/poll_status.sv
module poll_status
  import busy_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              busy,
  input  logic              launch,
  input  op_kind_t          op_kind,
  input  logic [DATA_W-1:0] op_data,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld
);
  localparam int LOW_W = DATA_W - 2;

  logic              tog;
  logic              rd_q;
  logic              rd_stat_q;
  logic              rd_tog_q;
  logic [DATA_W-1:0] status;

  always_comb begin
    if (op_kind == OP_ERASE)
      status = {1'b0, rd_tog_q, {LOW_W{1'b1}}};
    else
      status = {~op_data[DATA_W-1], rd_tog_q, op_data[LOW_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog       <= 1'b0;
      rd_q      <= 1'b0;
      rd_stat_q <= 1'b0;
      rd_tog_q  <= 1'b0;
      dout      <= '0;
      dout_vld  <= 1'b0;
    end else begin
      if (launch) tog <= 1'b0;
      else if (rd_en && busy) tog <= ~tog;
      rd_q      <= rd_en;
      rd_stat_q <= rd_en && busy;
      rd_tog_q  <= ~tog;
      dout_vld  <= rd_q;
      if (rd_q) dout <= rd_stat_q ? status : arr_rd_data;
    end
  end

  AST_TOG_FLIPS: assert property (@(posedge clk) disable iff (rst)
    (rd_en && busy && !launch) |=> (tog != $past(tog))); // R5
endmodule

// File: rtl/busy_status_gen.sv
module busy_status_gen
  import busy_status_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PROG_CYCLES  = 30,
  parameter int ERASE_CYCLES = 100,
  parameter int BOOT_WORDS   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              boot_lock,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              busy,
  output logic              err,
  output logic              arr_rd_en,
  output logic [ADDR_W-1:0] arr_rd_addr,
  input  logic [DATA_W-1:0] arr_rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic              launch;
  logic              fetch;
  logic [ADDR_W-1:0] fetch_addr;
  op_kind_t          op_kind;
  logic [DATA_W-1:0] op_data;
  op_kind_t          start_kind;

  assign start_kind  = start_erase ? OP_ERASE : OP_PROG;
  assign arr_rd_en   = fetch | rd_en;
  assign arr_rd_addr = fetch ? fetch_addr : rd_addr;

  op_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES), .BOOT_WORDS(BOOT_WORDS)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .start_kind(start_kind),
    .start_addr(start_addr), .start_data(start_data), .boot_lock(boot_lock),
    .arr_rd_data(arr_rd_data), .busy(busy), .err(err), .launch(launch),
    .op_kind(op_kind), .op_data(op_data), .fetch(fetch), .fetch_addr(fetch_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  poll_status #(.DATA_W(DATA_W)) u_poll (
    .clk(clk), .rst(rst), .rd_en(rd_en), .busy(busy), .launch(launch),
    .op_kind(op_kind), .op_data(op_data), .arr_rd_data(arr_rd_data),
    .dout(dout), .dout_vld(dout_vld)
  );

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R2
  AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R2
  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> ##1 dout_vld); // R6
  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op_kind == OP_PROG) |-> ((wr_data & ~arr_rd_data) == '0)); // R8
  AST_BOOT_KEPT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && boot_lock && op_kind == OP_ERASE) |-> (int'(wr_addr) >= BOOT_WORDS)); // R9
endmodule

// File: tb/tb_busy_status_gen.sv
`timescale 1ns/1ps
module tb_busy_status_gen;
  localparam int AW = 6, DW = 8, PC = 6, EC = 10, BW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1;
  logic start = 0, start_erase = 0, boot_lock = 0, rd_en = 0;
  logic [AW-1:0] start_addr = '0, rd_addr = '0;
  logic [DW-1:0] start_data = '0;
  logic [DW-1:0] dout, arr_rd_data, wr_data;
  logic dout_vld, busy, err, arr_rd_en, wr_en;
  logic [AW-1:0] arr_rd_addr, wr_addr;

  always #2.5 clk = ~clk;

  busy_status_gen #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC),
    .ERASE_CYCLES(EC), .BOOT_WORDS(BW)) dut (
    .clk(clk), .rst(rst), .start(start), .start_erase(start_erase),
    .start_addr(start_addr), .start_data(start_data), .boot_lock(boot_lock),
    .rd_en(rd_en), .rd_addr(rd_addr), .dout(dout), .dout_vld(dout_vld),
    .busy(busy), .err(err), .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr),
    .arr_rd_data(arr_rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  // array environment
  logic [DW-1:0] mem [DEPTH];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= DW'(i * 29 + 7);
      arr_rd_data <= '0;
    end else begin
      if (arr_rd_en) arr_rd_data <= mem[arr_rd_addr];
      if (wr_en) mem[wr_addr] <= wr_data;
    end
  end

  int n_chk = 0, n_fail = 0, cyc = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] ref_mem [DEPTH];
  int m_left, m_addr;
  bit m_erase, m_err, m_tog, m_lock;
  logic [DW-1:0] m_data, st_dout, e_dout;
  bit st_vld, e_vld, e_busy, e_err;
  string st_tag, e_tag;

  always @(posedge clk) begin
    if (rst) begin
      m_left = 0; m_err = 0; m_tog = 0; st_vld = 0; e_vld = 0;
      st_dout = 0; e_dout = 0; st_tag = "R7"; e_tag = "R7";
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = DW'(i * 29 + 7);
    end else begin
      e_vld = st_vld;
      if (st_vld) begin e_dout = st_dout; e_tag = st_tag; end
      st_vld = rd_en;
      if (rd_en) begin
        if (m_left > 0) begin
          m_tog = ~m_tog;
          if (m_erase) begin st_dout = {1'b0, m_tog, 6'h3F}; st_tag = "R4"; end
          else begin st_dout = {~m_data[7], m_tog, m_data[5:0]}; st_tag = "R3"; end
        end else begin
          st_dout = ref_mem[rd_addr]; st_tag = "R7";
        end
      end
      if (start && m_left == 0) begin
        m_erase = start_erase; m_addr = int'(start_addr); m_data = start_data;
        m_tog = 0;
        m_left = start_erase ? EC + DEPTH : PC + 2;
      end else begin
        if (start) m_err = 1;
        if (m_left > 0) begin
          m_left--;
          if (m_left == 0) begin
            if (m_erase) begin
              for (int i = 0; i < DEPTH; i++)
                if (!(boot_lock && i < BW)) ref_mem[i] = '1;
            end else begin
              ref_mem[m_addr] = ref_mem[m_addr] & m_data;
            end
          end
        end
      end
    end
    e_busy = (m_left > 0);
    e_err = m_err;
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(busy == e_busy, "R2 busy", busy, e_busy);
      chk(err == e_err, "R10 err", err, e_err);
      chk(dout_vld == e_vld, "R6 dout_vld", dout_vld, e_vld);
      if (e_vld && dout_vld) begin
        if (e_tag != "R7" && dout[6] != e_dout[6])
          chk(0, "R5 toggle bit", dout, e_dout);
        else
          chk(dout == e_dout, {e_tag, " dout"}, dout, e_dout);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++; n_chk++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic go(input bit er, input int a, input int d);
    @(negedge clk);
    start = 1; start_erase = er; start_addr = AW'(a); start_data = DW'(d);
    @(negedge clk);
    start = 0;
  endtask

  task automatic rd(input int a);
    @(negedge clk);
    rd_en = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic mem_cmp(input string tag);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++)
      chk(mem[i] == ref_mem[i], tag, mem[i], ref_mem[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(busy == 0 && err == 0 && dout_vld == 0 && wr_en == 0 && dout == 0,
        "R1 reset outputs", {busy, err, dout_vld, wr_en}, 0);
    @(negedge clk); rst = 0;
    @(negedge clk);
    chk(busy == 0 && err == 0 && dout_vld == 0 && wr_en == 0 && dout == 0,
        "R1 after reset", {busy, err, dout_vld, wr_en}, 0);
    // R7 idle reads
    rd(3); rd(10); rd(63);
    repeat (3) @(negedge clk);
    // R3 R5 R10: program with reads every cycle and a stray start
    go(0, 5, 8'h3C);
    @(negedge clk); rd_en = 1; rd_addr = 5;
    repeat (3) @(negedge clk);
    start = 1; start_erase = 1;
    @(negedge clk); start = 0; start_erase = 0;
    repeat (2) @(negedge clk); rd_en = 0;
    wait_idle();
    repeat (3) @(negedge clk);
    mem_cmp("R8 program merge");
    rd(5);
    // program bit7 = 0 into boot area; back-to-back start (R11)
    go(0, 2, 8'h55);
    rd(2); rd(2); rd(40);
    wait_idle();
    start = 1; start_erase = 0; start_addr = 9; start_data = 8'hF0;
    @(negedge clk); start = 0;
    chk(busy == 1, "R11 start on first idle cycle", busy, 1);
    wait_idle();
    repeat (3) @(negedge clk);
    mem_cmp("R8 second programs");
    // erase with boot lock (R4 R9)
    boot_lock = 1;
    go(1, 0, 0);
    rd(1); rd(1); rd(1);
    wait_idle();
    repeat (3) @(negedge clk);
    mem_cmp("R9 locked erase");
    rd(2); rd(20);
    // program a zero then erase without lock
    boot_lock = 0;
    go(0, 1, 8'h00);
    wait_idle();
    go(1, 0, 0);
    rd(7); rd(7);
    wait_idle();
    repeat (3) @(negedge clk);
    mem_cmp("R9 full erase");
    rd(1); rd(0);
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule